// File: doc/BRIEF.md
# Bus Transceiver Power Mode Controller

This block is the digital mode controller of a fault-tolerant, low-speed bus transceiver. Two control inputs from the protocol controller choose the operating mode: normal, power-on standby, standby, or go-to-sleep. Go-to-sleep is a timed transition. When its hold time runs out, the controller enters sleep and releases the external regulator enable.

In the low-power modes the controller watches for wake-up requests. A local request is a debounced level change on the wake input. A remote request is either bus line staying dominant for a minimum time. A request latches an interrupt flag and brings the regulator enable back.

The error and receive outputs change meaning with the mode. They carry the bus error flag and received data, the power-on flag, or the wake interrupt. A supply-good flag that drops forces a low-power mode.

A watchdog on the transmit data input blocks the transmitter if the input is held dominant too long, and releases it on the next recessive level. All time limits are parameters counted in clock cycles.

Top module: `tcvr_pwr_ctrl`

## Requirements
- R1: After each clock edge, `mode_o` follows the effective control pins sampled at that edge: stb=1,en=1 gives normal (code 0); stb=1,en=0 gives power-on standby (code 1); stb=0,en=0 gives standby (code 2); stb=0,en=1 gives go-to-sleep (code 3). Sleep is code 4.
- R2: Reset gives standby mode with `inh_o`=1, the power-on flag set and the wake interrupt clear (`err_n_o`=1 and `rxd_o`=1).
- R3: Sleep is entered only from go-to-sleep, and only after SLEEP_HOLD_CYC cycles in go-to-sleep with stb=0,en=1 still applied. In sleep `inh_o`=0, and pins stb=0 with any en value keep the block in sleep.
- R4: A wake-up request that is latched while in go-to-sleep, or that arrives at the hold expiry, prevents entry to sleep. Both `inh_o` and the go-to-sleep mode stay active.
- R5: A local wake-up is a change of `wake_i` whose new level is sampled on WAKE_DEB_CYC consecutive edges. A shorter pulse is ignored. A change made in normal mode sets no interrupt.
- R6: A remote wake-up is `canh_dom_i` or `canl_dom_i` sampled high on DOM_WAKE_CYC consecutive edges while in a low-power mode. A shorter dominant run is ignored.
- R7: A wake-up in sleep leaves sleep one cycle after the request is seen. The block goes to standby if en=0 and to go-to-sleep if en=1, and `inh_o` returns to 1.
- R8: In normal mode, `err_n_o` is the inverse of `bus_err_i` and `rxd_o` equals `rx_data_i`. In power-on standby, `err_n_o` is the inverted power-on flag and `rxd_o` is the inverted wake flag. In standby, go-to-sleep and sleep, both outputs are the inverted wake flag. The wake flag stays set until normal mode is entered.
- R9: The power-on flag is set by reset and in every cycle with `vbat_ok_i`=0. It is cleared when normal mode is entered.
- R10: While `vcc_ok_i`=0, both control pins are taken as 0, so normal mode cannot be entered.
- R11: While `vbat_ok_i`=0, the next mode is standby, whatever the pins are, so `inh_o` is 1.
- R12: `tx_en_o` is 1 only in normal mode when no time-out is pending. Low `txd_i` on TXD_TMO_CYC consecutive edges blocks the transmitter. A high `txd_i` at any edge re-arms it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Standby control pin |
| en_i | input | 1 | Enable control pin |
| txd_i | input | 1 | Transmit data, low is dominant |
| wake_i | input | 1 | Local wake level, already filtered |
| canh_dom_i | input | 1 | High bus line reads dominant |
| canl_dom_i | input | 1 | Low bus line reads dominant |
| vcc_ok_i | input | 1 | Logic supply above its power-on level |
| vbat_ok_i | input | 1 | Battery supply above its flag level |
| bus_err_i | input | 1 | Bus wiring failure flag from the failure detector |
| rx_data_i | input | 1 | Received bus data |
| mode_o | output | 3 | Current mode code |
| inh_o | output | 1 | Regulator enable, 0 means released |
| err_n_o | output | 1 | Error / power-on / wake output, active low |
| rxd_o | output | 1 | Receive data or wake interrupt, active low |
| tx_en_o | output | 1 | Transmitter enable |

## Verification
The bench builds the block with a wake debounce of 4 cycles, a dominant wake time of 6, a go-to-sleep hold of 10 and a transmit time-out of 8. These short limits let each window be probed one cycle short of and exactly at its boundary. They include a glitch below the debounce, a dominant run below the wake time, and a transmit-low burst one cycle short of blocking. They also let the hold expiry be raced by a remote wake. Supply drops are applied from normal mode and from sleep.

// File: rtl/tcvr_pwr_pkg.sv
`timescale 1ns/1ps
package tcvr_pwr_pkg;

    // Mode codes are visible on mode_o; the numeric values are part of the interface.
    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_PWRON   = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_GOTO    = 3'd3,
        MODE_SLEEP   = 3'd4
    } pmode_e;

endpackage

// File: rtl/tcvr_wake_det.sv
`timescale 1ns/1ps
module tcvr_wake_det #(
    parameter int WAKE_DEB_CYC = 16,
    parameter int DOM_WAKE_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    input  logic wake_i,
    input  logic canh_dom_i,
    input  logic canl_dom_i,
    output logic loc_evt_o,
    output logic rem_evt_o
);
    localparam int NLINES = 2;
    localparam int DEB_W  = $clog2(WAKE_DEB_CYC + 1);
    localparam int DOM_W  = $clog2(DOM_WAKE_CYC + 1);
    localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(WAKE_DEB_CYC - 1);
    localparam logic [DOM_W-1:0] DOM_LIM  = DOM_W'(DOM_WAKE_CYC);
    localparam logic [DOM_W-1:0] DOM_LAST = DOM_W'(DOM_WAKE_CYC - 1);

    // Local wake: a reference level plus a run counter of differing samples.
    typedef struct packed {
        logic             lvl;
        logic [DEB_W-1:0] cnt;
        logic             pulse;
    } loc_t;

    loc_t loc_d, loc_q;

    always_comb begin
        loc_d       = loc_q;
        loc_d.pulse = 1'b0;
        if (wake_i == loc_q.lvl) begin
            loc_d.cnt = '0;
        end else if (loc_q.cnt == DEB_LAST) begin
            loc_d.lvl   = wake_i;
            loc_d.cnt   = '0;
            loc_d.pulse = 1'b1;
        end else begin
            loc_d.cnt = loc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loc_q <= '0;
        else        loc_q <= loc_d;
    end

    assign loc_evt_o = loc_q.pulse;

    // Remote wake: one saturating dominant-run counter per bus line.
    logic [NLINES-1:0] dom_vec;
    logic [NLINES-1:0] dom_pulse;
    assign dom_vec = {canl_dom_i, canh_dom_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        typedef struct packed {
            logic [DOM_W-1:0] cnt;
            logic             pulse;
        } line_t;

        line_t ln_d, ln_q;

        always_comb begin
            ln_d       = ln_q;
            ln_d.pulse = 1'b0;
            if (!lp_i || !dom_vec[g]) begin
                ln_d.cnt = '0;
            end else if (ln_q.cnt != DOM_LIM) begin
                ln_d.cnt   = ln_q.cnt + 1'b1;
                ln_d.pulse = (ln_q.cnt == DOM_LAST);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ln_q <= '0;
            else        ln_q <= ln_d;
        end

        assign dom_pulse[g] = ln_q.pulse;
    end

    assign rem_evt_o = |dom_pulse;

endmodule

// File: rtl/tcvr_txd_guard.sv
`timescale 1ns/1ps
module tcvr_txd_guard #(
    parameter int TXD_TMO_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    output logic blk_o
);
    localparam int TMO_W = $clog2(TXD_TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TXD_TMO_CYC - 1);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             blk;
    } grd_t;

    grd_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (txd_i) begin
            g_d.cnt = '0;
            g_d.blk = 1'b0;
        end else if (!g_q.blk) begin
            if (g_q.cnt == TMO_LAST) begin
                g_d.blk = 1'b1;
                g_d.cnt = '0;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign blk_o = g_q.blk;

endmodule

// File: rtl/tcvr_mode_fsm.sv
`timescale 1ns/1ps
module tcvr_mode_fsm
    import tcvr_pwr_pkg::*;
#(
    parameter int SLEEP_HOLD_CYC = 1000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stb_i,
    input  logic   en_i,
    input  logic   vbat_ok_i,
    input  logic   loc_evt_i,
    input  logic   rem_evt_i,
    output pmode_e mode_o,
    output logic   por_o,
    output logic   wflag_o
);
    localparam int HOLD_W = $clog2(SLEEP_HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SLEEP_HOLD_CYC - 1);

    typedef struct packed {
        pmode_e            mode;
        logic              por;
        logic              wflag;
        logic [HOLD_W-1:0] hold;
    } fsm_t;

    fsm_t   st_d, st_q;
    pmode_e nxt;
    logic   wake_evt;
    logic   hold_done;

    always_comb begin
        st_d      = st_q;
        wake_evt  = (loc_evt_i | rem_evt_i) & (st_q.mode != MODE_NORMAL);
        hold_done = (st_q.hold == HOLD_LAST);

        // Next mode: a missing battery forces standby; sleep persists unless woken.
        if (!vbat_ok_i) begin
            nxt = MODE_STANDBY;
        end else if (stb_i && en_i) begin
            nxt = MODE_NORMAL;
        end else if (stb_i) begin
            nxt = MODE_PWRON;
        end else if (st_q.mode == MODE_SLEEP && !wake_evt) begin
            nxt = MODE_SLEEP;
        end else if (!en_i) begin
            nxt = MODE_STANDBY;
        end else if (st_q.mode == MODE_GOTO && hold_done && !st_q.wflag && !wake_evt) begin
            nxt = MODE_SLEEP;
        end else begin
            nxt = MODE_GOTO;
        end
        st_d.mode = nxt;

        // Hold counter runs only while go-to-sleep persists, saturating at its last value.
        if (nxt == MODE_GOTO && st_q.mode == MODE_GOTO) begin
            st_d.hold = hold_done ? st_q.hold : st_q.hold + 1'b1;
        end else begin
            st_d.hold = '0;
        end

        if (!vbat_ok_i)              st_d.por = 1'b1;
        else if (nxt == MODE_NORMAL) st_d.por = 1'b0;

        if (nxt == MODE_NORMAL) st_d.wflag = 1'b0;
        else if (wake_evt)      st_d.wflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_STANDBY;
            st_q.por   <= 1'b1;
            st_q.wflag <= 1'b0;
            st_q.hold  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign por_o   = st_q.por;
    assign wflag_o = st_q.wflag;

endmodule

// File: rtl/tcvr_pwr_ctrl.sv
`timescale 1ns/1ps
module tcvr_pwr_ctrl
    import tcvr_pwr_pkg::*;
#(
    parameter int WAKE_DEB_CYC   = 16,
    parameter int DOM_WAKE_CYC   = 32,
    parameter int SLEEP_HOLD_CYC = 1000,
    parameter int TXD_TMO_CYC    = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       wake_i,
    input  logic       canh_dom_i,
    input  logic       canl_dom_i,
    input  logic       vcc_ok_i,
    input  logic       vbat_ok_i,
    input  logic       bus_err_i,
    input  logic       rx_data_i,
    output logic [2:0] mode_o,
    output logic       inh_o,
    output logic       err_n_o,
    output logic       rxd_o,
    output logic       tx_en_o
);
    logic   stb_eff, en_eff;
    logic   low_pwr;
    logic   loc_evt, rem_evt;
    logic   txd_blk;
    logic   por_flag, wake_flag;
    pmode_e mode_q;

    // Without a logic supply the pins read as low, forcing a low-power mode.
    assign stb_eff = stb_i & vcc_ok_i;
    assign en_eff  = en_i & vcc_ok_i;
    assign low_pwr = (mode_q != MODE_NORMAL);

    tcvr_wake_det #(
        .WAKE_DEB_CYC (WAKE_DEB_CYC),
        .DOM_WAKE_CYC (DOM_WAKE_CYC)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_i       (low_pwr),
        .wake_i     (wake_i),
        .canh_dom_i (canh_dom_i),
        .canl_dom_i (canl_dom_i),
        .loc_evt_o  (loc_evt),
        .rem_evt_o  (rem_evt)
    );

    tcvr_txd_guard #(
        .TXD_TMO_CYC (TXD_TMO_CYC)
    ) u_txd (
        .clk   (clk),
        .rst_n (rst_n),
        .txd_i (txd_i),
        .blk_o (txd_blk)
    );

    tcvr_mode_fsm #(
        .SLEEP_HOLD_CYC (SLEEP_HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (stb_eff),
        .en_i      (en_eff),
        .vbat_ok_i (vbat_ok_i),
        .loc_evt_i (loc_evt),
        .rem_evt_i (rem_evt),
        .mode_o    (mode_q),
        .por_o     (por_flag),
        .wflag_o   (wake_flag)
    );

    // Output meaning depends on the mode.
    always_comb begin
        unique case (mode_q)
            MODE_NORMAL: begin
                err_n_o = ~bus_err_i;
                rxd_o   = rx_data_i;
            end
            MODE_PWRON: begin
                err_n_o = ~por_flag;
                rxd_o   = ~wake_flag;
            end
            default: begin
                err_n_o = ~wake_flag;
                rxd_o   = ~wake_flag;
            end
        endcase
    end

    assign mode_o  = mode_q;
    assign inh_o   = (mode_q != MODE_SLEEP);
    assign tx_en_o = (mode_q == MODE_NORMAL) & ~txd_blk;

endmodule

// File: rtl/tcvr_pwr_chk.sv
`timescale 1ns/1ps
module tcvr_pwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stb_i,
    input logic       en_i,
    input logic       txd_i,
    input logic       vcc_ok_i,
    input logic       vbat_ok_i,
    input logic [2:0] mode_o,
    input logic       inh_o,
    input logic       err_n_o,
    input logic       tx_en_o
);
    AST_PINS_SELECT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && en_i && vcc_ok_i && vbat_ok_i) |=> (mode_o == 3'd0)); // R1

    AST_SLEEP_ONLY_FROM_GOTO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'd4 && mode_o != 3'd3) |=> (mode_o != 3'd4)); // R3

    AST_WAKE_BLOCKS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && !err_n_o) |=> (mode_o != 3'd4)); // R4

    AST_NO_VCC_NO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok_i) |=> (mode_o != 3'd0)); // R10

    AST_NO_VBAT_INH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!vbat_ok_i) |=> (inh_o && mode_o == 3'd2)); // R11

    AST_TXD_HIGH_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_i && stb_i && en_i && vcc_ok_i && vbat_ok_i) |=> tx_en_o); // R12

endmodule

bind tcvr_pwr_ctrl tcvr_pwr_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_i     (stb_i),
    .en_i      (en_i),
    .txd_i     (txd_i),
    .vcc_ok_i  (vcc_ok_i),
    .vbat_ok_i (vbat_ok_i),
    .mode_o    (mode_o),
    .inh_o     (inh_o),
    .err_n_o   (err_n_o),
    .tx_en_o   (tx_en_o)
);

// File: tb/tcvr_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module tcvr_pwr_ctrl_tb_top;
    localparam int DEB  = 4;
    localparam int DOM  = 6;
    localparam int HOLD = 10;
    localparam int TMO  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0, en = 1'b0, txd = 1'b1, wake = 1'b0;
    logic canh = 1'b0, canl = 1'b0, vcc = 1'b1, vbat = 1'b1;
    logic bus_err = 1'b0, rx_data = 1'b1;
    logic [2:0] mode;
    logic inh, err_n, rxd, tx_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcvr_pwr_ctrl #(
        .WAKE_DEB_CYC   (DEB),
        .DOM_WAKE_CYC   (DOM),
        .SLEEP_HOLD_CYC (HOLD),
        .TXD_TMO_CYC    (TMO)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .en_i       (en),
        .txd_i      (txd),
        .wake_i     (wake),
        .canh_dom_i (canh),
        .canl_dom_i (canl),
        .vcc_ok_i   (vcc),
        .vbat_ok_i  (vbat),
        .bus_err_i  (bus_err),
        .rx_data_i  (rx_data),
        .mode_o     (mode),
        .inh_o      (inh),
        .err_n_o    (err_n),
        .rxd_o      (rxd),
        .tx_en_o    (tx_en)
    );

    // Behavioural reference model, advanced on each rising edge.
    int m_mode, m_por, m_wf, m_hold, m_wref, m_wcnt, m_lp, m_rp;
    int m_hc, m_lc, m_tc, m_blk;
    int s_e, e_e, nm, wevt, lowp, nrp, nlp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2; m_por = 1; m_wf = 0; m_hold = 0;
            m_wref = 0; m_wcnt = 0; m_lp = 0; m_rp = 0;
            m_hc = 0; m_lc = 0; m_tc = 0; m_blk = 0;
        end else begin
            s_e  = (stb && vcc) ? 1 : 0;
            e_e  = (en && vcc) ? 1 : 0;
            lowp = (m_mode != 0) ? 1 : 0;
            wevt = ((m_lp != 0 || m_rp != 0) && lowp != 0) ? 1 : 0;
            if (!vbat)                         nm = 2;
            else if (s_e != 0 && e_e != 0)     nm = 0;
            else if (s_e != 0)                 nm = 1;
            else if (m_mode == 4 && wevt == 0) nm = 4;
            else if (e_e == 0)                 nm = 2;
            else if (m_mode == 3 && m_hold == HOLD - 1 && m_wf == 0 && wevt == 0) nm = 4;
            else                               nm = 3;
            nlp = 0;
            if (int'(wake) == m_wref) m_wcnt = 0;
            else if (m_wcnt == DEB - 1) begin m_wref = int'(wake); m_wcnt = 0; nlp = 1; end
            else m_wcnt++;
            nrp = 0;
            if (lowp == 0 || !canh) m_hc = 0;
            else if (m_hc < DOM) begin if (m_hc == DOM - 1) nrp = 1; m_hc++; end
            if (lowp == 0 || !canl) m_lc = 0;
            else if (m_lc < DOM) begin if (m_lc == DOM - 1) nrp = 1; m_lc++; end
            if (txd) begin m_tc = 0; m_blk = 0; end
            else if (m_blk == 0) begin
                if (m_tc == TMO - 1) begin m_blk = 1; m_tc = 0; end
                else m_tc++;
            end
            if (nm == 3 && m_mode == 3) m_hold = (m_hold == HOLD - 1) ? m_hold : m_hold + 1;
            else m_hold = 0;
            if (!vbat) m_por = 1; else if (nm == 0) m_por = 0;
            if (nm == 0) m_wf = 0; else if (wevt != 0) m_wf = 1;
            m_mode = nm; m_lp = nlp; m_rp = nrp;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(mode), m_mode, "R1 mode");
            check(int'(inh), (m_mode != 4) ? 1 : 0, "R3 inh");
            check(int'(err_n), (m_mode == 0) ? int'(!bus_err) :
                               (m_mode == 1) ? 1 - m_por : 1 - m_wf, "R8 err_n");
            check(int'(rxd), (m_mode == 0) ? int'(rx_data) : 1 - m_wf, "R8 rxd");
            check(int'(tx_en), (m_mode == 0 && m_blk == 0) ? 1 : 0, "R12 tx_en");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pins(input logic s, input logic e);
        stb = s; en = e;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        at_neg();
        check(int'(mode), 2, "R2 reset mode");
        check(int'(inh), 1, "R2 reset inh");
        check(int'(err_n), 1, "R2 reset err_n");
        check(int'(rxd), 1, "R2 reset rxd");

        pins(1, 0); cyc(1); at_neg();
        check(int'(mode), 1, "R1 power-on standby");
        check(int'(err_n), 0, "R9 power-on flag shown");

        pins(1, 1); cyc(1); at_neg();
        check(int'(mode), 0, "R1 normal");
        check(int'(tx_en), 1, "R12 tx enabled");
        bus_err = 1'b1; rx_data = 1'b0; cyc(1); at_neg();
        check(int'(err_n), 0, "R8 error flag in normal");
        check(int'(rxd), 0, "R8 data in normal");
        bus_err = 1'b0; rx_data = 1'b1;

        pins(1, 0); cyc(1); at_neg();
        check(int'(err_n), 1, "R9 flag cleared by normal");
        pins(1, 1); cyc(1);

        txd = 1'b0; cyc(TMO - 1); at_neg();
        check(int'(tx_en), 1, "R12 below time-out");
        cyc(1); at_neg();
        check(int'(tx_en), 0, "R12 time-out blocks");
        txd = 1'b1; cyc(1); at_neg();
        check(int'(tx_en), 1, "R12 recessive re-arms");

        wake = 1'b1; cyc(10);
        pins(0, 0); cyc(1); at_neg();
        check(int'(err_n), 1, "R5 wake change in normal ignored");

        pins(0, 1); cyc(1); at_neg();
        check(int'(mode), 3, "R1 go-to-sleep");
        cyc(HOLD - 1); at_neg();
        check(int'(mode), 3, "R3 hold not yet done");
        cyc(1); at_neg();
        check(int'(mode), 4, "R3 sleep after hold");
        check(int'(inh), 0, "R3 inh released");
        pins(0, 0); cyc(3); at_neg();
        check(int'(mode), 4, "R3 sleep kept with pins low");

        wake = 1'b0; cyc(DEB - 1); wake = 1'b1; cyc(5); at_neg();
        check(int'(mode), 4, "R5 short wake glitch ignored");
        wake = 1'b0; cyc(DEB + 2); at_neg();
        check(int'(mode), 2, "R7 wake leaves sleep");
        check(int'(inh), 1, "R7 inh back");
        check(int'(err_n), 0, "R8 wake on err_n");
        check(int'(rxd), 0, "R8 wake on rxd");

        pins(0, 1); cyc(HOLD + 5); at_neg();
        check(int'(mode), 3, "R4 latched wake blocks sleep");

        pins(1, 1); cyc(1); at_neg();
        check(int'(rxd), 1, "R8 normal clears wake");
        pins(0, 1); cyc(1); cyc(1);
        canh = 1'b1; cyc(15); at_neg();
        check(int'(mode), 3, "R4 wake during hold keeps go-to-sleep");
        check(int'(err_n), 0, "R6 remote wake on high line");
        canh = 1'b0;

        pins(1, 1); cyc(1);
        pins(0, 1); cyc(HOLD + 2); at_neg();
        check(int'(mode), 4, "R3 sleep again");
        canl = 1'b1; cyc(DOM - 1); canl = 1'b0; cyc(2); at_neg();
        check(int'(mode), 4, "R6 short dominant ignored");
        canl = 1'b1; cyc(DOM + 2); at_neg();
        check(int'(mode), 3, "R7 wake with en high goes to go-to-sleep");
        check(int'(inh), 1, "R6 remote wake on low line");
        canl = 1'b0;

        pins(1, 1); cyc(1);
        vcc = 1'b0; cyc(1); at_neg();
        check(int'(mode), 2, "R10 missing logic supply forces standby");
        check(int'(tx_en), 0, "R10 no transmit");
        vcc = 1'b1; cyc(1); at_neg();
        check(int'(mode), 0, "R10 normal after supply returns");

        pins(0, 1); cyc(HOLD + 2);
        vbat = 1'b0; cyc(1); at_neg();
        check(int'(mode), 2, "R11 missing battery forces standby");
        check(int'(inh), 1, "R11 inh set");
        vbat = 1'b1; pins(1, 0); cyc(1); at_neg();
        check(int'(err_n), 0, "R9 flag set by battery loss");

        pins(1, 1); cyc(5); at_neg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule